// File: doc/BRIEF.md
# Four-Output PWM Group Generator

This block produces four pulse-width-modulated outputs from one shared period counter that advances once per clock. Software programs a period, a duty value for each output and a mode word through a simple write port. It then raises `en` to run the group. The counter either ramps up and wraps, which gives edge-aligned pulses that start at the period boundary. Or it ramps up to the half-period point and back down, which gives center-aligned pulses placed about the middle of the period.

All writes land in shadow registers. The working copies follow the shadows continuously while the group is disabled. While it runs, they reload only at a period start. In center-aligned mode the duty copies can also reload at the half-period point, so the two halves of one period may carry different widths. A paired mode turns each even/odd output pair into complementary signals. Per-output polarity bits choose the active level. A one-clock strobe marks the first clock of every period.

Top module: `pwm_grp`

## Requirements
- R1: With mode bit 0 clear (edge-aligned), `period_strobe_o` is high for exactly one clock, on the first clock of every period. Periods are P clocks long, where P is the programmed period. A programmed period below 2 behaves as 2.
- R2: In edge-aligned mode, with the output not paired, an output is active for the first min(D, P) clocks of each period, where D is its own duty value. D = 0 keeps it inactive for the whole period.
- R3: With mode bit 0 set (center-aligned), a period lasts 2H clocks, where H = floor(Pe/2) and Pe is the period after the rule in R1. The strobe marks the first of those clocks. With single update, an output is active on clocks H − floor(D/2) through H + floor(D/2) − 1 of the period, counting from 0, and is clipped to the period.
- R4: Write addresses are as follows: 0 is the period, 1 is the mode word, and 2 + i is the duty of output i. While the group runs, the written values take effect only from the next period start. While it is disabled, they take effect at once.
- R5: With mode bits 0 and 1 both set (double update), duty values present at clock H of a period apply to clocks H through 2H − 1 of that period. The first half keeps the values loaded at the period start.
- R6: With mode bit 2 set (paired), odd output 2k+1 is driven as the complement of the active state of output 2k, and its own duty value is ignored. Polarity then applies per output.
- R7: Mode bit 3 + i set makes output i active-low. When the bit is clear, output i is active-high.
- R8: After reset, all outputs and the strobe are 0. Within one clock of `en` going low, each output sits at its inactive level and the strobe is low. One clock after `en` is seen high, a new period begins with the strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances one step per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low holds the counter at zero and the outputs inactive |
| wr_en | input | 1 | Write strobe for the shadow registers |
| wr_addr | input | ADDR_W | Shadow register address (0 period, 1 mode, 2+i duty i) |
| wr_data | input | CNT_W | Write data |
| pwm_o | output | NUM_CH | PWM outputs |
| period_strobe_o | output | 1 | One-clock pulse on the first clock of each period |

## Verification
The assertions watch, on every cycle, the invariants that need no waveform model. The strobe is a single-clock pulse that only appears with the counter at zero. The counter stays inside its range for the active mode. The working period and pairing stay fixed between period starts. Paired outputs with equal polarity stay complementary. A zero duty never drives an output active, and disabling forces the inactive levels. Only the bench's sweeps can show the exact pulse placement: the edge-aligned widths, the centered windows for odd and even periods, the half-period duty change in double-update mode, and the one-period delay of writes made while the group runs.

// File: rtl/pwm_grp_pkg.sv
package pwm_grp_pkg;

    // direction of the center-aligned ramp
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

    // shadow register addresses
    localparam int unsigned REG_PERIOD    = 0;
    localparam int unsigned REG_MODE      = 1;
    localparam int unsigned REG_DUTY_BASE = 2;

    // mode word bit positions
    localparam int unsigned MODE_CENTER  = 0;
    localparam int unsigned MODE_DOUBLE  = 1;
    localparam int unsigned MODE_PAIRED  = 2;
    localparam int unsigned MODE_POL_LSB = 3;

endpackage

// File: rtl/pwm_grp_shadow.sv
module pwm_grp_shadow
    import pwm_grp_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned MODE_W = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [CNT_W-1:0]               wr_data,
    output logic [CNT_W-1:0]               period_o,
    output logic [MODE_W-1:0]              mode_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]   duty_o
);

    typedef struct packed {
        logic [CNT_W-1:0]             period;
        logic [MODE_W-1:0]            mode;
        logic [NUM_CH-1:0][CNT_W-1:0] duty;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(REG_PERIOD)) begin
                sh_d.period = wr_data;
            end
            if (wr_addr == ADDR_W'(REG_MODE)) begin
                sh_d.mode = wr_data[MODE_W-1:0];
            end
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (wr_addr == ADDR_W'(REG_DUTY_BASE + ch)) begin
                    sh_d.duty[ch] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign period_o = sh_q.period;
    assign mode_o   = sh_q.mode;
    assign duty_o   = sh_q.duty;

endmodule

// File: rtl/pwm_grp_timebase.sv
module pwm_grp_timebase
    import pwm_grp_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic             center_i,
    output logic [CNT_W-1:0] cnt_d_o,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic             run_q_o,
    output logic             start_o,
    output logic             mid_o
);

    typedef struct packed {
        logic             run;
        cnt_dir_e         dir;
        logic [CNT_W-1:0] cnt;
    } tb_t;

    tb_t              tb_d, tb_q;
    logic [CNT_W-1:0] eff_period;
    logic [CNT_W-1:0] half;

    always_comb begin
        eff_period = (period_i < CNT_W'(2)) ? CNT_W'(2) : period_i;
        half       = eff_period >> 1;
        tb_d       = tb_q;
        start_o    = 1'b0;
        mid_o      = 1'b0;
        if (!en_i) begin
            tb_d = '{run: 1'b0, dir: DIR_UP, cnt: '0};
        end else if (!tb_q.run) begin
            // first enabled edge opens a period
            tb_d    = '{run: 1'b1, dir: DIR_UP, cnt: '0};
            start_o = 1'b1;
        end else if (!center_i) begin
            tb_d.dir = DIR_UP;
            if (tb_q.cnt >= eff_period - CNT_W'(1)) begin
                tb_d.cnt = '0;
                start_o  = 1'b1;
            end else begin
                tb_d.cnt = tb_q.cnt + CNT_W'(1);
            end
        end else if (tb_q.dir == DIR_UP) begin
            // top of the ramp: value repeats, second half opens
            if (tb_q.cnt >= half - CNT_W'(1)) begin
                tb_d.dir = DIR_DOWN;
                mid_o    = 1'b1;
            end else begin
                tb_d.cnt = tb_q.cnt + CNT_W'(1);
            end
        end else begin
            if (tb_q.cnt == '0) begin
                tb_d.dir = DIR_UP;
                start_o  = 1'b1;
            end else begin
                tb_d.cnt = tb_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb_q <= '{run: 1'b0, dir: DIR_UP, cnt: '0};
        end else begin
            tb_q <= tb_d;
        end
    end

    assign cnt_d_o = tb_d.cnt;
    assign cnt_q_o = tb_q.cnt;
    assign run_q_o = tb_q.run;

endmodule

// File: rtl/pwm_grp_compare.sv
module pwm_grp_compare #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned NUM_CH = 4
) (
    input  logic                         en_i,
    input  logic [CNT_W-1:0]             cnt_i,
    input  logic [CNT_W-1:0]             period_i,
    input  logic                         center_i,
    input  logic                         paired_i,
    input  logic [NUM_CH-1:0]            pol_i,
    input  logic [NUM_CH-1:0][CNT_W-1:0] duty_i,
    output logic [NUM_CH-1:0]            pins_o
);

    logic [CNT_W-1:0]  eff_period;
    logic [CNT_W-1:0]  half;
    logic [NUM_CH-1:0] raw;

    always_comb begin
        eff_period = (period_i < CNT_W'(2)) ? CNT_W'(2) : period_i;
        half       = eff_period >> 1;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic sel;

        // center: active while ramp value plus half the duty reaches the top
        assign raw[ch] = center_i
            ? (({1'b0, cnt_i} + {2'b0, duty_i[ch][CNT_W-1:1]}) >= {1'b0, half})
            : (cnt_i < duty_i[ch]);

        if (ch % 2 == 1) begin : g_odd
            assign sel = paired_i ? ~raw[ch-1] : raw[ch];
        end else begin : g_even
            assign sel = raw[ch];
        end

        assign pins_o[ch] = en_i ? (sel ^ pol_i[ch]) : pol_i[ch];
    end

endmodule

// File: rtl/pwm_grp.sv
module pwm_grp
    import pwm_grp_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = $clog2(NUM_CH + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NUM_CH-1:0] pwm_o,
    output logic              period_strobe_o
);

    localparam int unsigned MODE_W = MODE_POL_LSB + NUM_CH;

    typedef struct packed {
        logic [CNT_W-1:0]             period;
        logic                         center;
        logic                         dbl;
        logic                         paired;
        logic [NUM_CH-1:0]            pol;
        logic [NUM_CH-1:0][CNT_W-1:0] duty;
    } act_t;

    typedef struct packed {
        logic [NUM_CH-1:0] pins;
        logic              strobe;
    } out_t;

    act_t act_d, act_q;
    out_t out_d, out_q;

    logic [CNT_W-1:0]             sh_period;
    logic [MODE_W-1:0]            sh_mode;
    logic [NUM_CH-1:0][CNT_W-1:0] sh_duty;

    logic [CNT_W-1:0]  cnt_d_w;
    logic [CNT_W-1:0]  cnt_q_w;
    logic              run_q_w;
    logic              start_w;
    logic              mid_w;
    logic [NUM_CH-1:0] pins_w;

    // views of the working bank for the bound checker
    logic [CNT_W-1:0]             act_period_w;
    logic                         act_center_w;
    logic                         act_paired_w;
    logic [NUM_CH-1:0]            act_pol_w;
    logic [NUM_CH-1:0][CNT_W-1:0] act_duty_w;

    pwm_grp_shadow #(
        .CNT_W  (CNT_W),
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .MODE_W (MODE_W)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .period_o (sh_period),
        .mode_o   (sh_mode),
        .duty_o   (sh_duty)
    );

    pwm_grp_timebase #(
        .CNT_W (CNT_W)
    ) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en),
        .period_i (act_q.period),
        .center_i (act_q.center),
        .cnt_d_o  (cnt_d_w),
        .cnt_q_o  (cnt_q_w),
        .run_q_o  (run_q_w),
        .start_o  (start_w),
        .mid_o    (mid_w)
    );

    pwm_grp_compare #(
        .CNT_W  (CNT_W),
        .NUM_CH (NUM_CH)
    ) u_compare (
        .en_i     (en),
        .cnt_i    (cnt_d_w),
        .period_i (act_d.period),
        .center_i (act_d.center),
        .paired_i (act_d.paired),
        .pol_i    (act_d.pol),
        .duty_i   (act_d.duty),
        .pins_o   (pins_w)
    );

    always_comb begin
        act_d = act_q;
        if (!en || start_w) begin
            act_d.period = sh_period;
            act_d.center = sh_mode[MODE_CENTER];
            act_d.dbl    = sh_mode[MODE_DOUBLE];
            act_d.paired = sh_mode[MODE_PAIRED];
            act_d.pol    = sh_mode[MODE_POL_LSB +: NUM_CH];
            act_d.duty   = sh_duty;
        end else if (mid_w && act_q.center && act_q.dbl) begin
            act_d.duty = sh_duty;
        end
        out_d.pins   = pins_w;
        out_d.strobe = start_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
            out_q <= '0;
        end else begin
            act_q <= act_d;
            out_q <= out_d;
        end
    end

    assign pwm_o           = out_q.pins;
    assign period_strobe_o = out_q.strobe;

    assign act_period_w = act_q.period;
    assign act_center_w = act_q.center;
    assign act_paired_w = act_q.paired;
    assign act_pol_w    = act_q.pol;
    assign act_duty_w   = act_q.duty;

endmodule

// File: rtl/pwm_grp_checker.sv
module pwm_grp_checker #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned NUM_CH = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         en,
    input logic [NUM_CH-1:0]            pins,
    input logic                         strobe,
    input logic [CNT_W-1:0]             cnt,
    input logic                         run,
    input logic [CNT_W-1:0]             act_period,
    input logic                         act_center,
    input logic                         act_paired,
    input logic [NUM_CH-1:0]            act_pol,
    input logic [NUM_CH-1:0][CNT_W-1:0] act_duty
);

    logic [CNT_W-1:0] lim_edge;
    logic [CNT_W-1:0] lim_half;

    always_comb begin
        lim_edge = (act_period < CNT_W'(2)) ? CNT_W'(2) : act_period;
        lim_half = lim_edge >> 1;
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe); // R1

    AST_STROBE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (cnt == '0)); // R1

    AST_EDGE_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !act_center) |-> (cnt < lim_edge)); // R1

    AST_CENTER_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act_center) |-> (cnt < lim_half)); // R3

    AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !strobe) |-> ($stable(act_period) && $stable(act_paired) && $stable(act_center))); // R4

    AST_PAIR_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act_paired && (act_pol[0] == act_pol[1])) |-> (pins[0] != pins[1])); // R6

    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ((pins == act_pol) && !strobe)); // R8

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_zero
        AST_ZERO_DUTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (run && (act_duty[ch] == '0) && ((ch % 2 == 0) || !act_paired))
                |-> (pins[ch] == act_pol[ch])); // R2
    end

endmodule

bind pwm_grp pwm_grp_checker #(
    .CNT_W  (CNT_W),
    .NUM_CH (NUM_CH)
) u_pwm_grp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .pins       (pwm_o),
    .strobe     (period_strobe_o),
    .cnt        (cnt_q_w),
    .run        (run_q_w),
    .act_period (act_period_w),
    .act_center (act_center_w),
    .act_paired (act_paired_w),
    .act_pol    (act_pol_w),
    .act_duty   (act_duty_w)
);

// File: tb/pwm_grp_bench.sv
`timescale 1ns/1ps
module pwm_grp_bench;

    localparam int CW = 8;
    localparam int NC = 4;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [NC-1:0] pwm;
    logic          strobe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    pwm_grp #(.CNT_W(CW), .NUM_CH(NC)) u_pwm_grp (
        .clk             (clk),
        .rst_n           (rst_n),
        .en              (en),
        .wr_en           (wr_en),
        .wr_addr         (wr_addr),
        .wr_data         (wr_data),
        .pwm_o           (pwm),
        .period_strobe_o (strobe)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic reg_write(input int addr, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = AW'(addr);
        wr_data = CW'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Programs a case while idle, enables, and checks every clock.
    // With upd set, the duties d2 are written during the first period.
    task automatic run_case(input string req, input int p, input bit center,
                            input bit dbl, input bit paired, input int pol,
                            input int d1 [NC], input int d2 [NC],
                            input bit upd, input int extra);
        int pe, h, len, total, m, pidx, dsel;
        bit second;
        bit act [NC];
        logic [NC-1:0] exp_pins;
        @(negedge clk);
        en = 1'b0;
        reg_write(0, p);
        reg_write(1, int'(center) | (int'(dbl) << 1) | (int'(paired) << 2) | (pol << 3));
        for (int ch = 0; ch < NC; ch++) reg_write(2 + ch, d1[ch]);
        pe    = (p < 2) ? 2 : p;
        h     = pe / 2;
        len   = center ? 2 * h : pe;
        total = 2 * len + extra;
        en    = 1'b1;
        for (int k = 0; k < total; k++) begin
            @(negedge clk);
            m      = k % len;
            pidx   = k / len;
            second = upd && ((pidx > 0) || (center && dbl && (m >= h)));
            for (int ch = 0; ch < NC; ch++) begin
                dsel = second ? d2[ch] : d1[ch];
                if (!center)    act[ch] = (m < dsel);
                else if (m < h) act[ch] = (m >= h - dsel / 2);
                else            act[ch] = (m < h + dsel / 2);
            end
            for (int ch = 0; ch < NC; ch++) begin
                if (paired && (ch % 2 == 1)) exp_pins[ch] = (!act[ch-1]) ^ pol[ch];
                else                         exp_pins[ch] = act[ch] ^ pol[ch];
            end
            check(req, int'(pwm), int'(exp_pins));
            check("R1 R3 strobe", int'(strobe), (m == 0) ? 1 : 0);
            if (upd && (k >= 1) && (k <= 4)) begin
                wr_en   = 1'b1;
                wr_addr = AW'(2 + k - 1);
                wr_data = CW'(d2[k-1]);
            end else begin
                wr_en = 1'b0;
            end
        end
        wr_en = 1'b0;
        en    = 1'b0;
        @(negedge clk);
        check("R8 idle levels", int'(pwm), pol & 15);
        check("R8 idle strobe", int'(strobe), 0);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset pins", int'(pwm), 0);
        check("R8 reset strobe", int'(strobe), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 disabled pins", int'(pwm), 0);
        check("R8 disabled strobe", int'(strobe), 0);

        // edge-aligned sweep, zero and saturating duties, update at boundary
        for (int p = 12; p < 20; p++)
            run_case("R1 R2 R4 edge", p, 1'b0, 1'b0, 1'b0, 0,
                     '{0, p / 3, p - 1, p + 5}, '{p, 1, p / 2, 0}, 1'b1, 0);

        // period values below 2 behave as 2
        for (int p = 0; p < 4; p++)
            run_case("R1 clamp edge", p, 1'b0, 1'b0, 1'b0, 0,
                     '{0, 1, 2, 1}, '{0, 1, 2, 1}, 1'b0, 3);
        for (int p = 2; p < 4; p++)
            run_case("R3 clamp center", p, 1'b1, 1'b0, 1'b0, 0,
                     '{0, 1, 2, 9}, '{0, 1, 2, 9}, 1'b0, 1);

        // center single update, odd and even periods, mixed polarity
        for (int p = 12; p < 22; p++)
            run_case("R3 R4 R7 center single", p, 1'b1, 1'b0, 1'b0, 10,
                     '{0, 2, p / 2, p}, '{p + 4, 5, 1, 3}, 1'b1, 3);

        // center double update, new duties from the half-period point
        for (int p = 14; p < 22; p++)
            run_case("R5 center double", p, 1'b1, 1'b1, 1'b0, 0,
                     '{3, p, 6, 0}, '{8, 1, 0, p}, 1'b1, 2);

        // paired outputs, odd duties must have no effect
        run_case("R6 paired edge", 16, 1'b0, 1'b0, 1'b1, 0,
                 '{5, 1, 11, 1}, '{9, 0, 16, 0}, 1'b1, 0);
        run_case("R6 R7 paired edge polarity", 16, 1'b0, 1'b0, 1'b1, 6,
                 '{5, 13, 0, 7}, '{16, 2, 3, 9}, 1'b1, 5);
        run_case("R5 R6 paired center double", 20, 1'b1, 1'b1, 1'b1, 15,
                 '{6, 2, 20, 0}, '{2, 9, 0, 4}, 1'b1, 7);

        done = 1'b1;
        finish_up();
    end

endmodule